// File: doc/BRIEF.md
# HEX Image to Word-Memory Loader

This block accepts a program image written in the Intel HEX text format, one ASCII character per accepted transfer, and turns it into write operations for a program memory organised as 16-bit words. Each record is parsed for its data length, 16-bit load offset, record type, payload and trailing checksum. The payload is held back until the checksum has been confirmed. Only then is it replayed as word writes, one per clock.

HEX addresses count bytes while the target memory holds one 16-bit word per address. The block therefore halves the byte address to form the word address, and it uses the byte address's lowest bit to pick the lane: low lane for an even byte, high lane for an odd byte. A record that begins or finishes on an odd byte produces a partial write with a two-bit lane mask. Records are placed purely by their own address, so gaps and any arrival order are allowed. An upper-address record supplies bits 31..16 of the byte address, and an end-of-image record stops the loader.

Top module: `hex_word_loader`

## Requirements
- R1: After reset, wr_en, done, cksum_err and fmt_err are low, ch_ready is high, and the upper base is zero.
- R2: Each byte of a data record lives at byte address B = {base[15:0], offset} + index. Its word address is B shifted right by one, and bit 0 of B selects the lane (0 = wr_data[7:0], 1 = wr_data[15:8]).
- R3: Two bytes that share a word are written together with wr_mask = 2'b11. The lower-addressed byte goes in wr_data[7:0] and the next byte in wr_data[15:8].
- R4: A word with only one byte present is written with wr_mask 2'b01 (low lane) or 2'b10 (high lane). The unused lane of wr_data is zero, and wr_mask is never 2'b00 while wr_en is high.
- R5: Records are written at their own addresses whatever their arrival order or spacing. A data record with zero length produces no write.
- R6: The 8-bit sum of every decoded byte in a record, checksum included, must be zero. Otherwise cksum_err pulses for one cycle and the record produces no writes and no base change.
- R7: A type 0x04 record with exactly two payload bytes sets base[15:0]. The first byte becomes bits 15..8. The base persists for later records.
- R8: A valid type 0x01 record raises done. done then stays high until reset, and all further characters produce no write and no error pulse.
- R9: Hex digits are accepted in both upper case and lower case.
- R10: Outside a record, CR (0x0D) and LF (0x0A) are ignored. Any other character except ':' (0x3A) pulses fmt_err.
- R11: A non-hex character inside a record pulses fmt_err and drops the record. The loader then waits for the next ':'.
- R12: A length field larger than MAX_DATA, or a record type other than 0x00, 0x01 or 0x04, pulses fmt_err and the record produces no writes.
- R13: While the writes of a record are pending, ch_ready is low. The writes of one record come out on consecutive cycles with word addresses increasing by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | A character is offered on ch_data |
| ch_data | input | 8 | ASCII character |
| ch_ready | output | 1 | Loader can take a character; a transfer happens when ch_valid and ch_ready are both high at a clock edge |
| wr_en | output | 1 | Word write strobe, one cycle per word |
| wr_addr | output | 31 | Word address (byte address shifted right by one) |
| wr_data | output | 16 | Little-endian word data; unused lane is zero |
| wr_mask | output | 2 | Lane enables: bit 0 for the low byte, bit 1 for the high byte |
| done | output | 1 | End-of-image record seen; held until reset |
| cksum_err | output | 1 | One-cycle pulse on a record with a bad checksum |
| fmt_err | output | 1 | One-cycle pulse on a malformed character, length or type |

## Verification
The bench builds the loader with MAX_DATA set to 16. This makes the oversize-length rejection reachable with a three-character header, while the largest accepted record still fills the whole payload buffer and produces a full run of eight consecutive words. The default of 255 changes only the buffer depth and counter widths. Upper-base switching, odd starts and odd ends, zero-length records and out-of-order offsets all fit comfortably inside that smaller buffer.

// File: rtl/hexld_pkg.sv
package hexld_pkg;

  typedef enum logic [1:0] {P_IDLE, P_BODY, P_DONE} pstate_e;

  // {valid, nibble} for one ASCII character
  function automatic logic [4:0] hex_nib(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39) return {1'b1, 4'(c - 8'h30)};
    if (c >= 8'h41 && c <= 8'h46) return {1'b1, 4'(c - 8'h37)};
    if (c >= 8'h61 && c <= 8'h66) return {1'b1, 4'(c - 8'h57)};
    return 5'd0;
  endfunction

  // byte address to 16-bit word address
  function automatic logic [30:0] word_of(input logic [31:0] b);
    return b[31:1];
  endfunction

endpackage

// File: rtl/hexld_char_dec.sv
module hexld_char_dec
  import hexld_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_colon,
  output logic       is_eol,
  output logic       is_hex,
  output logic [3:0] nib
);
  logic [4:0] dec;
  always_comb begin
    dec      = hex_nib(ch);
    is_hex   = dec[4];
    nib      = dec[3:0];
    is_colon = (ch == 8'h3A);
    is_eol   = (ch == 8'h0D) || (ch == 8'h0A);
  end
endmodule

// File: rtl/hexld_rec_parser.sv
module hexld_rec_parser
  import hexld_pkg::*;
#(
  parameter int MAX_DATA = 255
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic                         is_colon,
  input  logic                         is_eol,
  input  logic                         is_hex,
  input  logic [3:0]                   nib,
  input  logic [$clog2(MAX_DATA)-1:0]  rd_i0,
  input  logic [$clog2(MAX_DATA)-1:0]  rd_i1,
  output logic [7:0]                   rd_b0,
  output logic [7:0]                   rd_b1,
  output logic                         rec_ok,
  output logic [31:0]                  rec_addr,
  output logic [7:0]                   rec_cnt,
  output logic                         done,
  output logic                         cksum_err,
  output logic                         fmt_err
);
  localparam int IW = $clog2(MAX_DATA + 6);
  localparam int BW = $clog2(MAX_DATA);

  pstate_e        st;
  logic           phase;
  logic [3:0]     hi_nib;
  logic [IW-1:0]  bidx;
  logic [7:0]     sum, cnt, rtype;
  logic [15:0]    off, base_hi;
  logic [7:0]     dbuf [2**BW];

  logic           byte_done, last_byte, in_data;
  logic [7:0]     cur_byte, sum_fin;
  logic [BW-1:0]  widx;

  always_comb begin
    cur_byte  = {hi_nib, nib};
    byte_done = take && (st == P_BODY) && is_hex && phase;
    last_byte = byte_done && (int'(bidx) >= 4) && (int'(bidx) == int'(cnt) + 4);
    in_data   = byte_done && (int'(bidx) >= 4) && !last_byte;
    sum_fin   = sum + cur_byte;
    widx      = BW'(bidx - IW'(4));
    rec_ok    = last_byte && (sum_fin == 8'd0) && (rtype == 8'h00);
    rec_addr  = {base_hi, off};
    rec_cnt   = cnt;
    done      = (st == P_DONE);
    rd_b0     = dbuf[rd_i0];
    rd_b1     = dbuf[rd_i1];
  end

  always_ff @(posedge clk) begin
    if (in_data) dbuf[widx] <= cur_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= P_IDLE; phase <= 1'b0; hi_nib <= '0; bidx <= '0;
      sum <= '0; cnt <= '0; rtype <= '0; off <= '0; base_hi <= '0;
      cksum_err <= 1'b0; fmt_err <= 1'b0;
    end else begin
      cksum_err <= 1'b0;
      fmt_err   <= 1'b0;
      if (take) begin
        case (st)
          P_IDLE: begin
            if (is_colon) begin
              st <= P_BODY; phase <= 1'b0; bidx <= '0; sum <= '0;
            end else if (!is_eol) begin
              fmt_err <= 1'b1;
            end
          end
          P_BODY: begin
            if (!is_hex) begin
              fmt_err <= 1'b1;
              st      <= P_IDLE;
            end else if (!phase) begin
              hi_nib <= nib;
              phase  <= 1'b1;
            end else begin
              phase <= 1'b0;
              sum   <= sum_fin;
              bidx  <= bidx + IW'(1);
              if (bidx == IW'(0)) begin
                cnt <= cur_byte;
                if (int'(cur_byte) > MAX_DATA) begin
                  fmt_err <= 1'b1;
                  st      <= P_IDLE;
                end
              end else if (bidx == IW'(1)) off[15:8] <= cur_byte;
              else if (bidx == IW'(2)) off[7:0] <= cur_byte;
              else if (bidx == IW'(3)) rtype <= cur_byte;
              else if (last_byte) begin
                st <= P_IDLE;
                if (sum_fin != 8'd0) cksum_err <= 1'b1;
                else begin
                  case (rtype)
                    8'h00: ;
                    8'h01: st <= P_DONE;
                    8'h04: begin
                      if (cnt == 8'd2) base_hi <= {dbuf[0], dbuf[1]};
                      else fmt_err <= 1'b1;
                    end
                    default: fmt_err <= 1'b1;
                  endcase
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hexld_word_emit.sv
module hexld_word_emit
  import hexld_pkg::*;
#(
  parameter int MAX_DATA = 255
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [31:0]                  base_addr,
  input  logic [7:0]                   count,
  input  logic [7:0]                   rd_b0,
  input  logic [7:0]                   rd_b1,
  output logic [$clog2(MAX_DATA)-1:0]  rd_i0,
  output logic [$clog2(MAX_DATA)-1:0]  rd_i1,
  output logic                         busy,
  output logic                         wr_en,
  output logic [30:0]                  wr_addr,
  output logic [15:0]                  wr_data,
  output logic [1:0]                   wr_mask
);
  localparam int BW = $clog2(MAX_DATA);

  logic [8:0]  p, n, step;
  logic [31:0] cur;
  logic        odd, pair;

  always_comb begin
    odd   = cur[0];
    pair  = !odd && ((p + 9'd1) < n);
    step  = pair ? 9'd2 : 9'd1;
    rd_i0 = BW'(p);
    rd_i1 = BW'(p + 9'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; p <= '0; n <= '0; cur <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_mask <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start) begin
        busy <= (count != 8'd0);
        p    <= '0;
        n    <= {1'b0, count};
        cur  <= base_addr;
      end else if (busy) begin
        wr_en   <= 1'b1;
        wr_addr <= word_of(cur);
        if (odd) begin
          wr_mask <= 2'b10; wr_data <= {rd_b0, 8'h00};
        end else if (pair) begin
          wr_mask <= 2'b11; wr_data <= {rd_b1, rd_b0};
        end else begin
          wr_mask <= 2'b01; wr_data <= {8'h00, rd_b0};
        end
        p   <= p + step;
        cur <= cur + 32'(step);
        if ((p + step) >= n) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hex_word_loader.sv
module hex_word_loader #(
  parameter int MAX_DATA = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ch_valid,
  input  logic [7:0]  ch_data,
  output logic        ch_ready,
  output logic        wr_en,
  output logic [30:0] wr_addr,
  output logic [15:0] wr_data,
  output logic [1:0]  wr_mask,
  output logic        done,
  output logic        cksum_err,
  output logic        fmt_err
);
  localparam int BW = $clog2(MAX_DATA);

  logic          take, is_colon, is_eol, is_hex;
  logic [3:0]    nib;
  logic          rec_ok, emit_busy;
  logic [31:0]   rec_addr;
  logic [7:0]    rec_cnt, rd_b0, rd_b1;
  logic [BW-1:0] rd_i0, rd_i1;

  assign ch_ready = !emit_busy;
  assign take     = ch_valid && ch_ready;

  hexld_char_dec u_dec (
    .ch(ch_data), .is_colon(is_colon), .is_eol(is_eol), .is_hex(is_hex), .nib(nib)
  );

  hexld_rec_parser #(.MAX_DATA(MAX_DATA)) u_parse (
    .clk(clk), .rst_n(rst_n), .take(take),
    .is_colon(is_colon), .is_eol(is_eol), .is_hex(is_hex), .nib(nib),
    .rd_i0(rd_i0), .rd_i1(rd_i1), .rd_b0(rd_b0), .rd_b1(rd_b1),
    .rec_ok(rec_ok), .rec_addr(rec_addr), .rec_cnt(rec_cnt),
    .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err)
  );

  hexld_word_emit #(.MAX_DATA(MAX_DATA)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(rec_ok),
    .base_addr(rec_addr), .count(rec_cnt),
    .rd_b0(rd_b0), .rd_b1(rd_b1), .rd_i0(rd_i0), .rd_i1(rd_i1),
    .busy(emit_busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask)
  );
endmodule

// File: rtl/hexld_chk.sv
module hexld_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ch_ready,
  input logic        wr_en,
  input logic [30:0] wr_addr,
  input logic [15:0] wr_data,
  input logic [1:0]  wr_mask,
  input logic        done,
  input logic        cksum_err,
  input logic        fmt_err
);
  // R4
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_mask != 2'b00);
  // R4
  hi_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask == 2'b10) |-> wr_data[7:0] == 8'h00);
  // R4
  lo_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask == 2'b01) |-> wr_data[15:8] == 8'h00);
  // R13
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 31'd1);
  // R13
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(ch_ready));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> (!wr_en && !cksum_err && !fmt_err));
  // R6
  ck_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |=> !wr_en);
endmodule

bind hex_word_loader hexld_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_ready(ch_ready), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
  .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err)
);

// File: tb/hex_word_loader_tb.sv
module hex_word_loader_tb_top;
  localparam int MAXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_valid = 1'b0;
  logic [7:0]  ch_data = 8'h00;
  logic        ch_ready, wr_en, done, cksum_err, fmt_err;
  logic [30:0] wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_mask;

  always #10 clk = ~clk;

  hex_word_loader #(.MAX_DATA(MAXD)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err)
  );

  int total = 0, bad = 0;
  int nlog = 0, nexp = 0, nck = 0, nfe = 0, cyc = 0;
  logic [30:0] la [64];
  logic [15:0] ld [64];
  logic [1:0]  lm [64];
  int          lc [64];
  logic [30:0] ea [64];
  logic [15:0] ed [64];
  logic [1:0]  em [64];
  logic [7:0]  rb [32];
  logic        rdy_after;
  logic [15:0] cur_base = 16'h0000;

  // {base16, offset16, length8, seed8}
  localparam logic [47:0] VEC [7] = '{
    {16'h0000, 16'h0000, 8'd16, 8'h10},
    {16'h0000, 16'h0101, 8'd5,  8'h40},
    {16'h0000, 16'h0020, 8'd3,  8'h60},
    {16'h0000, 16'h0011, 8'd1,  8'h80},
    {16'h0000, 16'h0300, 8'd0,  8'h90},
    {16'h0002, 16'h0008, 8'd2,  8'hA0},
    {16'h0000, 16'h0040, 8'd4,  8'hC0}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (wr_en && nlog < 64) begin
        la[nlog] = wr_addr; ld[nlog] = wr_data; lm[nlog] = wr_mask; lc[nlog] = cyc;
        nlog++;
      end
      if (cksum_err) nck++;
      if (fmt_err) nfe++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    while (!ch_ready) @(negedge clk);
    ch_valid = 1'b1; ch_data = c;
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  function automatic logic [7:0] to_asc(input logic [3:0] v, input bit lower);
    if (v < 4'd10) return 8'h30 + 8'(v);
    return (lower ? 8'h61 : 8'h41) + 8'(v) - 8'd10;
  endfunction

  task automatic send_hex(input logic [7:0] b, input bit lower);
    send_char(to_asc(b[7:4], lower));
    send_char(to_asc(b[3:0], lower));
  endtask

  task automatic send_record(input logic [7:0] typ, input logic [15:0] off,
                             input int n, input bit lower, input bit badck);
    logic [7:0] s;
    s = 8'(n) + off[15:8] + off[7:0] + typ;
    for (int i = 0; i < n; i++) s += rb[i];
    s = 8'h00 - s + (badck ? 8'h01 : 8'h00);
    send_char(8'h3A);
    send_hex(8'(n), lower); send_hex(off[15:8], lower); send_hex(off[7:0], lower);
    send_hex(typ, lower);
    for (int i = 0; i < n; i++) send_hex(rb[i], lower);
    send_hex(s, lower);
    rdy_after = ch_ready;
    send_char(8'h0D); send_char(8'h0A);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (!ch_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // bench model: group bytes by word, lane from address bit 0
  task automatic expect_rec(input logic [31:0] a, input int n);
    int i = 0;
    while (i < n) begin
      logic [31:0] w;
      logic [15:0] d;
      logic [1:0]  m;
      w = (a + 32'(i)) >> 1; d = '0; m = '0;
      while (i < n && ((a + 32'(i)) >> 1) == w) begin
        if (((a + 32'(i)) & 32'd1) != 0) begin d[15:8] = rb[i]; m[1] = 1'b1; end
        else begin d[7:0] = rb[i]; m[0] = 1'b1; end
        i++;
      end
      ea[nexp] = w[30:0]; ed[nexp] = d; em[nexp] = m; nexp++;
    end
  endtask

  task automatic compare_writes(input string req);
    chk(nlog == nexp, {req, " write count"}, nlog, nexp);
    for (int k = 0; k < nlog && k < nexp; k++) begin
      chk(la[k] == ea[k], {req, " addr"}, la[k], ea[k]);
      chk(ld[k] == ed[k], {req, " data"}, ld[k], ed[k]);
      chk(lm[k] == em[k], {req, " mask"}, lm[k], em[k]);
    end
    nlog = 0; nexp = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R13 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0, c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_en && !done && !cksum_err && !fmt_err, "R1 outputs idle in reset",
        {wr_en, done, cksum_err, fmt_err}, 0);
    chk(ch_ready == 1'b1, "R1 ready in reset", ch_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table of records: R2 R3 R4 R5 R7 R9 R13
    for (int v = 0; v < 7; v++) begin
      logic [15:0] vb, vo;
      int vn;
      logic [7:0] vs;
      vb = VEC[v][47:32]; vo = VEC[v][31:16]; vn = int'(VEC[v][15:8]); vs = VEC[v][7:0];
      if (vb != cur_base) begin
        rb[0] = vb[15:8]; rb[1] = vb[7:0];
        send_record(8'h04, 16'h0000, 2, 1'b0, 1'b0);
        settle();
        cur_base = vb;
        compare_writes("R7 base record writes nothing");
      end
      for (int i = 0; i < vn; i++) rb[i] = vs + 8'(7 * i);
      expect_rec({cur_base, vo}, vn);
      send_record(8'h00, vo, vn, v[0], 1'b0);
      if (vn > 1) chk(rdy_after == 1'b0, "R13 ready low while writing", rdy_after, 0);
      settle();
      if (nlog > 1) chk(lc[nlog-1] - lc[0] == nlog - 1, "R13 consecutive writes",
                        lc[nlog-1] - lc[0], nlog - 1);
      compare_writes(v[0] ? "R9 R2 R3 R4 R5 lower-case record" : "R2 R3 R4 R5 record");
    end

    // R7 directed: base 0x0001, words 0x8002..0x8003
    rb[0] = 8'h00; rb[1] = 8'h01;
    send_record(8'h04, 16'h0000, 2, 1'b1, 1'b0);
    settle();
    rb[0] = 8'h11; rb[1] = 8'h22; rb[2] = 8'h33; rb[3] = 8'h44;
    ea[0] = 31'h8002; ed[0] = 16'h2211; em[0] = 2'b11;
    ea[1] = 31'h8003; ed[1] = 16'h4433; em[1] = 2'b11; nexp = 2;
    send_record(8'h00, 16'h0004, 4, 1'b0, 1'b0);
    settle();
    compare_writes("R7 upper base applied");
    rb[0] = 8'h00; rb[1] = 8'h00;
    send_record(8'h04, 16'h0000, 2, 1'b0, 1'b0);
    settle();

    // R6 bad checksum
    c0 = nck;
    for (int i = 0; i < 4; i++) rb[i] = 8'h55 + 8'(i);
    send_record(8'h00, 16'h0050, 4, 1'b0, 1'b1);
    settle();
    chk(nck == c0 + 1, "R6 checksum error pulse", nck - c0, 1);
    compare_writes("R6 no writes on bad checksum");

    // R10 CR/LF ignored, stray character flagged
    f0 = nfe;
    send_char(8'h0D); send_char(8'h0A); send_char(8'h0A);
    settle();
    chk(nfe == f0, "R10 CR LF ignored", nfe - f0, 0);
    send_char(8'h78);
    settle();
    chk(nfe == f0 + 1, "R10 stray char error", nfe - f0, 1);

    // R11 bad character inside record, then recovery
    f0 = nfe;
    send_char(8'h3A); send_char(8'h30); send_char(8'h32); send_char(8'h47);
    settle();
    chk(nfe == f0 + 1, "R11 non-hex in record", nfe - f0, 1);
    rb[0] = 8'hDE; rb[1] = 8'hAD;
    expect_rec(32'h0000_0060, 2);
    send_record(8'h00, 16'h0060, 2, 1'b0, 1'b0);
    settle();
    compare_writes("R11 recovery record");

    // R12 oversize length and unknown type
    f0 = nfe;
    send_char(8'h3A); send_hex(8'd17, 1'b0); send_char(8'h0D); send_char(8'h0A);
    settle();
    chk(nfe == f0 + 1, "R12 oversize length", nfe - f0, 1);
    compare_writes("R12 no writes oversize");
    f0 = nfe;
    send_record(8'h02, 16'h0070, 2, 1'b0, 1'b0);
    settle();
    chk(nfe == f0 + 1, "R12 unknown type", nfe - f0, 1);
    compare_writes("R12 no writes unknown type");

    // R8 end of image
    chk(done == 1'b0, "R8 done low before end record", done, 0);
    send_record(8'h01, 16'h0000, 0, 1'b0, 1'b0);
    settle();
    chk(done == 1'b1, "R8 done raised", done, 1);
    f0 = nfe; c0 = nck;
    rb[0] = 8'h01; rb[1] = 8'h02;
    send_record(8'h00, 16'h0080, 2, 1'b0, 1'b0);
    send_char(8'h78);
    settle();
    compare_writes("R8 input ignored after done");
    chk(nfe == f0 && nck == c0, "R8 no error pulses after done", nfe - f0 + nck - c0, 0);
    chk(done == 1'b1, "R8 done held", done, 1);

    // R1 reset clears done
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && ch_ready == 1'b1, "R1 reset clears done", {done, ch_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule